// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two parallel data ports, A and B, and holds one storage latch for each direction of flow. The A-to-B path takes data from A, keeps it in its own latch and presents it on B. The B-to-A path does the same thing in the other direction and has its own latch. Each path has three active-low controls: a path enable, a latch-open control and a drive control. Together they decide whether the path's latch follows its source or keeps its contents, and whether the far port is driven.

Real tri-state nets are not used. Each port appears as an input vector, an output vector and an active-high per-bit drive-enable vector. A pad ring or bus fabric outside the block resolves these. The latch is modelled as a register that is refreshed on every clock edge while the path is open. The far port also sees the live source value combinationally during that time, so an open path behaves as a wire.

Several integrators can place two or more of these side by side on a shared bus. Each one stores a word and releases it to the other side under software or sequencer control.

Top module: `xcvr_latched_transceiver`

## Requirements
- R1: While a path's enable and latch-open control are both low, its latch is open. When its drive control is also low, the far-port output equals the source-port input in the same cycle, with no clock edge in between.
- R2: When the latch-open control is high and the enable is low, the path holds the source value it sampled at the last rising clock edge at which it was open. Later source changes do not affect the far-port output.
- R3: When a path's enable is high, its latch keeps its contents whatever the latch-open control does. After the enable returns low with the latch-open control high, the far port shows the contents from before.
- R4: The far-port drive-enable vector is all ones only when the path's enable and drive control are both low. Otherwise it is all zeros, and it is never a partial mix.
- R5: While the far-port drive-enable vector is zero, the far-port output vector is zero.
- R6: Raising the drive control and lowering it again does not change the path's stored contents.
- R7: The B-to-A path follows R1 to R6 with its own three controls, with B as source and A as far port.
- R8: The controls of one path have no effect on the other path's stored contents, drive-enable vector or output.
- R9: An active-low asynchronous reset clears both latches to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which open latches sample their source |
| rst_n | input | 1 | Active-low asynchronous reset, clears both latches |
| a_in | input | W | Value present on port A (source of A-to-B path) |
| a_out | output | W | Value the B-to-A path drives onto port A |
| a_oe | output | W | Per-bit drive enable for port A, active high |
| b_in | input | W | Value present on port B (source of B-to-A path) |
| b_out | output | W | Value the A-to-B path drives onto port B |
| b_oe | output | W | Per-bit drive enable for port B, active high |
| ab_en_n | input | 1 | A-to-B path enable, active low |
| ab_open_n | input | 1 | A-to-B latch-open control, active low |
| ab_drv_n | input | 1 | A-to-B drive control, active low |
| ba_en_n | input | 1 | B-to-A path enable, active low |
| ba_open_n | input | 1 | B-to-A latch-open control, active low |
| ba_drv_n | input | 1 | B-to-A drive control, active low |

## Verification
The bench looks for the value held at closing. A design that captured one edge late, or that kept following the source once the latch-open control rose, shows the newer source word instead of the older one. Two cases exercise the enable gating. A design that let the latch open with the enable high overwrites the stored word in the enable-high/latch-low case. A design that gated only drive, and not capture, fails the load-while-undriven case. Toggling the drive control checks that drive gating leaves storage untouched. Cross-path stimulus checks that a shared or swapped control would disturb the other direction's held word.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        PATH_OFF  = 2'd0,
        PATH_HOLD = 2'd1,
        PATH_OPEN = 2'd2
    } path_mode_e;

    function automatic path_mode_e decode_mode(input logic en_n, input logic open_n);
        if (en_n)        return PATH_OFF;
        else if (open_n) return PATH_HOLD;
        else             return PATH_OPEN;
    endfunction

endpackage

// File: rtl/xcvr_path_ctrl.sv
module xcvr_path_ctrl
    import xcvr_pkg::*;
(
    input  logic       en_n,
    input  logic       open_n,
    input  logic       drv_n,
    output path_mode_e mode,
    output logic       drive
);

    always_comb begin
        mode  = decode_mode(en_n, open_n);
        drive = (mode != PATH_OFF) && !drv_n;
    end

endmodule

// File: rtl/xcvr_path_store.sv
module xcvr_path_store
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  path_mode_e   mode,
    input  logic [W-1:0] src,
    output logic [W-1:0] view
);

    typedef struct packed {
        logic [W-1:0] held;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode == PATH_OPEN) begin
            st_d.held = src;
        end
        view = (mode == PATH_OPEN) ? src : st_q.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/xcvr_path_drive.sv
module xcvr_path_drive #(
    parameter int W = 8
) (
    input  logic         drive,
    input  logic [W-1:0] view,
    output logic [W-1:0] dout,
    output logic [W-1:0] doe
);

    always_comb begin
        doe  = {W{drive}};
        dout = drive ? view : '0;
    end

endmodule

// File: rtl/xcvr_latched_transceiver.sv
module xcvr_latched_transceiver
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         ab_en_n,
    input  logic         ab_open_n,
    input  logic         ab_drv_n,
    input  logic         ba_en_n,
    input  logic         ba_open_n,
    input  logic         ba_drv_n
);

    localparam int NPATH = 2;
    localparam int P_AB  = 0;
    localparam int P_BA  = 1;

    logic [NPATH-1:0][W-1:0] src;
    logic [NPATH-1:0][W-1:0] view;
    logic [NPATH-1:0][W-1:0] dout;
    logic [NPATH-1:0][W-1:0] doe;
    logic [NPATH-1:0]        en_n;
    logic [NPATH-1:0]        open_n;
    logic [NPATH-1:0]        drv_n;
    logic [NPATH-1:0]        drive;
    path_mode_e              mode [NPATH];

    always_comb begin
        src[P_AB]    = a_in;
        src[P_BA]    = b_in;
        en_n[P_AB]   = ab_en_n;
        en_n[P_BA]   = ba_en_n;
        open_n[P_AB] = ab_open_n;
        open_n[P_BA] = ba_open_n;
        drv_n[P_AB]  = ab_drv_n;
        drv_n[P_BA]  = ba_drv_n;
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        xcvr_path_ctrl u_ctrl (
            .en_n   (en_n[p]),
            .open_n (open_n[p]),
            .drv_n  (drv_n[p]),
            .mode   (mode[p]),
            .drive  (drive[p])
        );

        xcvr_path_store #(.W(W)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode[p]),
            .src   (src[p]),
            .view  (view[p])
        );

        xcvr_path_drive #(.W(W)) u_drive (
            .drive (drive[p]),
            .view  (view[p]),
            .dout  (dout[p]),
            .doe   (doe[p])
        );
    end

    always_comb begin
        b_out = dout[P_AB];
        b_oe  = doe[P_AB];
        a_out = dout[P_BA];
        a_oe  = doe[P_BA];
    end

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe,
    input logic         ab_en_n,
    input logic         ab_open_n,
    input logic         ab_drv_n,
    input logic         ba_en_n,
    input logic         ba_open_n,
    input logic         ba_drv_n
);

    a_r1_ab_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_en_n && !ab_open_n && !ab_drv_n) |-> (b_out == a_in));

    a_r7_ba_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_en_n && !ba_open_n && !ba_drv_n) |-> (a_out == b_in));

    a_r2_ab_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_open_n && $past(ab_open_n) && !ab_en_n && !$past(ab_en_n)
         && !ab_drv_n && !$past(ab_drv_n)) |-> $stable(b_out));

    a_r7_ba_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_open_n && $past(ba_open_n) && !ba_en_n && !$past(ba_en_n)
         && !ba_drv_n && !$past(ba_drv_n)) |-> $stable(a_out));

    a_r4_b_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe == '0) || (&b_oe));

    a_r4_a_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe == '0) || (&a_oe));

    a_r4_b_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_en_n || ab_drv_n) |-> (b_oe == '0));

    a_r5_b_zero_when_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe == '0) |-> (b_out == '0));

    a_r5_a_zero_when_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe == '0) |-> (a_out == '0));

endmodule

bind xcvr_latched_transceiver xcvr_checker #(.W(W)) u_xcvr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_in      (b_in),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .ab_en_n   (ab_en_n),
    .ab_open_n (ab_open_n),
    .ab_drv_n  (ab_drv_n),
    .ba_en_n   (ba_en_n),
    .ba_open_n (ba_open_n),
    .ba_drv_n  (ba_drv_n)
);

// File: tb/tb_xcvr_latched_transceiver.sv
module tb_xcvr_latched_transceiver;

    localparam int  W         = 8;
    localparam time CLK_PER   = 10;
    localparam int  WATCHDOG  = 200000;
    localparam int  NVEC      = 11;

    // {en_n, open_n, drv_n, a_in, exp_b_oe, exp_b_out}
    localparam logic [3+W+1+W-1:0] VEC [NVEC] = '{
        {3'b000, 8'h3C, 1'b1, 8'h3C},   // R1 open, follows
        {3'b000, 8'hA5, 1'b1, 8'hA5},   // R1 open, follows
        {3'b010, 8'h11, 1'b1, 8'hA5},   // R2 closed, holds A5
        {3'b010, 8'hFF, 1'b1, 8'hA5},   // R2 still holds
        {3'b011, 8'hFF, 1'b0, 8'h00},   // R4 R5 drive off
        {3'b010, 8'h00, 1'b1, 8'hA5},   // R6 drive back, same word
        {3'b100, 8'h77, 1'b0, 8'h00},   // R3 R4 enable high
        {3'b010, 8'h77, 1'b1, 8'hA5},   // R3 latch untouched
        {3'b111, 8'h42, 1'b0, 8'h00},   // R4 all off
        {3'b001, 8'h42, 1'b0, 8'h00},   // R4 open but undriven, loads 42
        {3'b010, 8'h99, 1'b1, 8'h42}    // R2 load while undriven held
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         ab_en_n = 1'b1, ab_open_n = 1'b1, ab_drv_n = 1'b1;
    logic         ba_en_n = 1'b1, ba_open_n = 1'b1, ba_drv_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    xcvr_latched_transceiver #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_en_n(ab_en_n), .ab_open_n(ab_open_n), .ab_drv_n(ab_drv_n),
        .ba_en_n(ba_en_n), .ba_open_n(ba_open_n), .ba_drv_n(ba_drv_n)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PER * WATCHDOG);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset: R9, everything undriven
        repeat (3) step();
        #1;
        chk("R9 reset b_oe", b_oe, '0);
        chk("R9 reset a_oe", a_oe, '0);
        rst_n = 1'b1;
        step();
        ab_en_n = 1'b0; ab_drv_n = 1'b0;
        ba_en_n = 1'b0; ba_drv_n = 1'b0;
        a_in = 8'hEE; b_in = 8'hDD;
        #1;
        chk("R9 ab latch cleared", b_out, 8'h00);
        chk("R9 ba latch cleared", a_out, 8'h00);
        chk("R4 b_oe driven", b_oe, '1);
        step();
        ab_en_n = 1'b1; ab_drv_n = 1'b1;
        ba_en_n = 1'b1; ba_drv_n = 1'b1;

        // Table walk for the A-to-B path
        for (int i = 0; i < NVEC; i++) begin
            step();
            {ab_en_n, ab_open_n, ab_drv_n} = VEC[i][3+W+1+W-1 -: 3];
            a_in = VEC[i][W+1+W-1 -: W];
            #1;
            chk($sformatf("R1-vector %0d b_oe", i), b_oe, {W{VEC[i][W]}});
            chk($sformatf("R2-vector %0d b_out", i), b_out, VEC[i][W-1:0]);
            chk($sformatf("R8 vector %0d a_oe", i), a_oe, '0);
        end

        // R1: combinational follow within one cycle
        step();
        ab_en_n = 1'b0; ab_open_n = 1'b0; ab_drv_n = 1'b0;
        a_in = 8'h12;
        #1;
        chk("R1 follow first", b_out, 8'h12);
        a_in = 8'h34;
        #1;
        chk("R1 follow no edge", b_out, 8'h34);
        step();
        a_in = 8'h5A;
        step();
        ab_open_n = 1'b1;
        a_in = 8'h00;
        #1;
        chk("R2 hold after close", b_out, 8'h5A);

        // R7: B-to-A path load and hold
        step();
        ba_en_n = 1'b0; ba_open_n = 1'b0; ba_drv_n = 1'b0;
        b_in = 8'hC3;
        #1;
        chk("R7 ba open follows", a_out, 8'hC3);
        chk("R7 ba a_oe", a_oe, '1);
        step();
        ba_open_n = 1'b1;
        b_in = 8'h0F;
        #1;
        chk("R7 ba holds", a_out, 8'hC3);
        step();
        ba_drv_n = 1'b1;
        #1;
        chk("R7 ba undriven a_out", a_out, 8'h00);
        chk("R7 ba undriven a_oe", a_oe, '0);
        step();
        ba_drv_n = 1'b0;
        ba_en_n = 1'b1; ba_open_n = 1'b0;
        b_in = 8'hF0;
        step();
        ba_en_n = 1'b0; ba_open_n = 1'b1;
        #1;
        chk("R7 ba enable-high keeps word", a_out, 8'hC3);

        // R8: AB controls do not disturb BA and vice versa
        step();
        ab_open_n = 1'b0; ab_drv_n = 1'b1;
        a_in = 8'h66;
        step();
        a_in = 8'h77;
        step();
        ab_en_n = 1'b1;
        #1;
        chk("R8 ba word after ab activity", a_out, 8'hC3);
        ab_en_n = 1'b0; ab_open_n = 1'b1; ab_drv_n = 1'b0;
        #1;
        chk("R8 ab captured last open word", b_out, 8'h77);
        step();
        ba_open_n = 1'b0;
        b_in = 8'h81;
        step();
        ba_en_n = 1'b1; ba_open_n = 1'b1; ba_drv_n = 1'b1;
        b_in = 8'h00;
        #1;
        chk("R8 ab word after ba activity", b_out, 8'h77);
        chk("R8 ab drive after ba off", b_oe, '1);
        ba_en_n = 1'b0; ba_drv_n = 1'b0;
        #1;
        chk("R8 ba captured its own word", a_out, 8'h81);

        step();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule